// File: doc/BRIEF.md
# Line 21 Closed Caption Encoder

This block produces the digital luma waveform for closed-caption data on a 525-line raster clocked at 27 MHz. On line 21 of field one and on line 284 of field two, each gated by its own enable, it drives a caption burst into the luma path. The burst is a sine-like clock run-in, three start bits, and two characters. Each character is seven data bits followed by an odd-parity bit that the block computes itself. The output is a level code plus a gate that tells the downstream mixer when to substitute the caption level for the normal luma.

The bit cell lasts 1716/32 = 53.625 clocks, so cell edges are spread by a fractional accumulator. A host loads four character bytes through a small write port: two for field one and two for field two. Each field has a status flag that rises on a write and falls once the bytes have been sent. Sent bytes are cleared, so a slot the host misses carries null characters. Writes that arrive while a caption line is being sent are held back and land once that line is complete.

Top module: `cc_line21_enc`

## Requirements
- R1: After reset, `cc_active` is 0, `luma_code` equals the 0 IRE code (16), and both status flags are 0.
- R2: A burst starts only when `hpos` equals 284 and either `line_num` is 21 with `field2`=0 and `en_f1`=1, or `line_num` is 284 with `field2`=1 and `en_f2`=1. No other line, field or enable setting raises `cc_active` or changes the stored bytes or status.
- R3: `cc_active` rises two clocks after the start cycle and stays high for 51 half cells of 1716/64 clocks each, which is 1368 clocks (±2).
- R4: The first 13 half cells carry the run-in. This is a ramp that rises in even half cells and falls in odd ones, with 7 upward crossings of the mid level 68.
- R5: After the run-in come three bit cells with the values 0, 0 and 1.
- R6: Each character then follows as bits 0 to 6 in LSB-first order, plus an eighth bit that makes the count of ones odd. Character one comes from address 0 (field one) or address 2 (field two). Character two comes from address 1 or address 3.
- R7: At each bit-cell midpoint, logic 0 is code 16 (0 IRE) and logic 1 is code 120 (50 IRE). While the gate is high, every code lies within 16..120.
- R8: A write to address 0 or 1 sets `status_f1`, and a write to address 2 or 3 sets `status_f2`, on the next clock. A field's flag clears when its burst completes.
- R9: After a burst, that field's bytes are zero, so an unwritten slot sends 0x80 (data 0, parity 1).
- R10: A write made while a burst is in progress does not alter that burst. It takes effect for the next burst, and that field's status remains high.
- R11: While `cc_active` is 0, `luma_code` is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | synchronous active-low reset |
| line_num | input | 10 | current frame line, 1..525 |
| field2 | input | 1 | 1 during the second field |
| hpos | input | 11 | clock count within the line, 0..1715 |
| wr_en | input | 1 | host byte write strobe |
| wr_addr | input | 2 | byte select: 0/1 field one chars, 2/3 field two chars |
| wr_data | input | 7 | character data |
| en_f1 | input | 1 | enable caption in field one |
| en_f2 | input | 1 | enable caption in field two |
| luma_code | output | 8 | caption luma level code |
| cc_active | output | 1 | gate: caption level valid |
| status_f1 | output | 1 | field one bytes pending |
| status_f2 | output | 1 | field two bytes pending |

## Verification
The assertions assume that `hpos` advances by one per clock and that `line_num` and `field2` stay steady across a line. They also assume `hpos` wraps before 1716, so that no two start cycles fall inside a single burst. The stimulus sweeps whole lines in that way and changes line, field and enables only between lines. Host writes fall at arbitrary positions, including in the middle of a burst. Characters are random values chosen from a fixed seed, mixed with directed null, disabled and wrong-field lines.

// File: rtl/cc_line21_pkg.sv
// Shared constants and helpers for the caption encoder.
// Assumes a 1716-clock line and a bit cell of one 32nd of a line.
package cc_line21_pkg;
    localparam int LINE_CLKS     = 1716;
    localparam int CELLS_PER_LN  = 32;
    localparam int HALF_STEP     = 2 * CELLS_PER_LN;
    localparam int RUNIN_HALVES  = 13;
    localparam int FRAME_BITS    = 19;
    localparam int TOTAL_HALVES  = RUNIN_HALVES + 2 * FRAME_BITS;
    localparam int CHAR_W        = 7;

    typedef logic [CHAR_W-1:0] char_t;

    // Odd parity bit for a 7-bit character.
    function automatic logic odd_par(input char_t c);
        return ~(^c);
    endfunction
endpackage

// File: rtl/cc_half_timer.sv
// Fractional half-cell timer: fires a tick every LINE_CLKS/STEP clocks on
// average (26.8125), and reports the clock count within the half cell.
// Assumes restart is pulsed once before run rises.
module cc_half_timer #(
    parameter int LINE_CLKS = 1716,
    parameter int STEP      = 64,
    parameter int PW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    output logic          half_tick,
    output logic [PW-1:0] pcnt
);
    localparam int AW = $clog2(LINE_CLKS + STEP) + 1;

    logic [AW-1:0] acc;
    logic [AW-1:0] acc_sum;

    assign acc_sum   = acc + AW'(STEP);
    assign half_tick = run && (acc_sum >= AW'(LINE_CLKS));

    // Advance the phase accumulator and the in-cell clock count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc  <= '0;
            pcnt <= '0;
        end else if (run) begin
            if (half_tick) begin
                acc  <= acc_sum - AW'(LINE_CLKS);
                pcnt <= '0;
            end else begin
                acc  <= acc_sum;
                pcnt <= pcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cc_char_regs.sv
// Host character bytes with per-field status and a pending buffer for
// writes arriving during a burst. Assumes done pulses once per burst.
module cc_char_regs
    import cc_line21_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  char_t       wr_data,
    input  logic        busy,
    input  logic        done,
    input  logic        done_field,
    output char_t       bytes_q [4],
    output logic [1:0]  status
);
    char_t pend    [4];
    logic  [3:0] pend_v;
    char_t pend_d  [4];
    logic  [3:0] pend_vd;
    logic  [1:0] pend_any;

    // Merge the current write into the pending view.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            pend_d[i]  = pend[i];
            pend_vd[i] = pend_v[i];
        end
        if (wr_en) begin
            pend_d[wr_addr]  = wr_data;
            pend_vd[wr_addr] = 1'b1;
        end
        pend_any = {pend_vd[3] | pend_vd[2], pend_vd[1] | pend_vd[0]};
    end

    // Store bytes, buffer in-burst writes, clear sent bytes at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                bytes_q[i] <= '0;
                pend[i]    <= '0;
            end
            pend_v <= '0;
            status <= '0;
        end else if (done) begin
            for (int i = 0; i < 4; i++) begin
                if (pend_vd[i])
                    bytes_q[i] <= pend_d[i];
                else if ((i / 2) == int'(done_field))
                    bytes_q[i] <= '0;
            end
            pend_v <= '0;
            for (int f = 0; f < 2; f++) begin
                if (f == int'(done_field))
                    status[f] <= pend_any[f];
                else
                    status[f] <= status[f] | pend_any[f];
            end
        end else if (wr_en) begin
            if (busy) begin
                pend[wr_addr]   <= wr_data;
                pend_v[wr_addr] <= 1'b1;
            end else begin
                bytes_q[wr_addr] <= wr_data;
            end
            status[wr_addr[1]] <= 1'b1;
        end
    end
endmodule

// File: rtl/cc_frame_seq.sv
// Burst sequencer: walks 13 run-in half cells then 19 bit cells and
// produces the level code. Assumes start only arrives while idle.
module cc_frame_seq
    import cc_line21_pkg::*;
#(
    parameter int          PW       = 6,
    parameter logic [7:0]  LEVEL_LO = 8'd16,
    parameter logic [7:0]  LEVEL_HI = 8'd120
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_field,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  half_tick,
    input  logic [PW-1:0]         pcnt,
    output logic                  active,
    output logic                  done,
    output logic                  cur_field,
    output logic [7:0]            level
);
    localparam int HW       = $clog2(TOTAL_HALVES + 1);
    localparam int SPAN     = int'(LEVEL_HI) - int'(LEVEL_LO);
    localparam int LVL_STEP = SPAN / (LINE_CLKS / HALF_STEP);

    logic [HW-1:0]         half_idx;
    logic [FRAME_BITS-1:0] frame;
    logic [HW-1:0]         data_half;
    logic [4:0]            bit_idx;
    logic [9:0]            ramp;

    assign done      = active && half_tick && (half_idx == HW'(TOTAL_HALVES - 1));
    assign data_half = half_idx - HW'(RUNIN_HALVES);
    assign bit_idx   = 5'(data_half >> 1);
    assign ramp      = 10'(pcnt) * 10'(LVL_STEP);

    // Track burst progress in half cells and hold the frame bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            half_idx  <= '0;
            frame     <= '0;
            cur_field <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            half_idx  <= '0;
            frame     <= frame_in;
            cur_field <= start_field;
        end else if (done) begin
            active <= 1'b0;
        end else if (active && half_tick) begin
            half_idx <= half_idx + 1'b1;
        end
    end

    // Pick the run-in ramp or the NRZ bit level.
    always_comb begin
        if (!active) begin
            level = LEVEL_LO;
        end else if (half_idx < HW'(RUNIN_HALVES)) begin
            if (!half_idx[0])
                level = (ramp >= 10'(SPAN)) ? LEVEL_HI : 8'(10'(LEVEL_LO) + ramp);
            else
                level = (ramp >= 10'(SPAN)) ? LEVEL_LO : 8'(10'(LEVEL_HI) - ramp);
        end else begin
            level = frame[bit_idx] ? LEVEL_HI : LEVEL_LO;
        end
    end
endmodule

// File: rtl/cc_line21_enc.sv
// Caption encoder top: picks the eligible line, assembles the frame with
// start code and parity, and registers the output level and gate.
// Assumes hpos counts 0..LINE_CLKS-1 and line/field are stable per line.
module cc_line21_enc
    import cc_line21_pkg::*;
#(
    parameter int          START_POS = 284,
    parameter int          LINE_F1   = 21,
    parameter int          LINE_F2   = 284,
    parameter logic [7:0]  LEVEL_LO  = 8'd16,
    parameter logic [7:0]  LEVEL_HI  = 8'd120
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  line_num,
    input  logic        field2,
    input  logic [10:0] hpos,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [6:0]  wr_data,
    input  logic        en_f1,
    input  logic        en_f2,
    output logic [7:0]  luma_code,
    output logic        cc_active,
    output logic        status_f1,
    output logic        status_f2
);
    localparam int PW = $clog2(LINE_CLKS / HALF_STEP + 2);

    logic                  start;
    logic                  active;
    logic                  done;
    logic                  cur_field;
    logic                  half_tick;
    logic [PW-1:0]         pcnt;
    logic [7:0]            level;
    logic [1:0]            status;
    char_t                 bytes_q [4];
    char_t                 c1, c2;
    logic [FRAME_BITS-1:0] frame_in;

    // Decide whether this clock opens a caption burst.
    always_comb begin
        start = !active && (hpos == 11'(START_POS)) &&
                (((line_num == 10'(LINE_F1)) && !field2 && en_f1) ||
                 ((line_num == 10'(LINE_F2)) &&  field2 && en_f2));
        c1 = field2 ? bytes_q[2] : bytes_q[0];
        c2 = field2 ? bytes_q[3] : bytes_q[1];
        frame_in = {odd_par(c2), c2, odd_par(c1), c1, 3'b100};
    end

    cc_half_timer #(.LINE_CLKS(LINE_CLKS), .STEP(HALF_STEP), .PW(PW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(active),
        .half_tick(half_tick), .pcnt(pcnt)
    );

    cc_frame_seq #(.PW(PW), .LEVEL_LO(LEVEL_LO), .LEVEL_HI(LEVEL_HI)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_field(field2),
        .frame_in(frame_in), .half_tick(half_tick), .pcnt(pcnt),
        .active(active), .done(done), .cur_field(cur_field), .level(level)
    );

    cc_char_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(active | start), .done(done),
        .done_field(cur_field), .bytes_q(bytes_q), .status(status)
    );

    // Register the output level and gate together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            luma_code <= LEVEL_LO;
            cc_active <= 1'b0;
        end else begin
            luma_code <= level;
            cc_active <= active;
        end
    end

    assign status_f1 = status[0];
    assign status_f2 = status[1];
endmodule

// File: rtl/cc_line21_enc_chk.sv
// Property checker for the caption encoder, bound to the top module.
// Assumes the input protocol stated in the brief.
module cc_line21_enc_chk #(
    parameter int          START_POS = 284,
    parameter int          LINE_F1   = 21,
    parameter int          LINE_F2   = 284,
    parameter logic [7:0]  LEVEL_LO  = 8'd16,
    parameter logic [7:0]  LEVEL_HI  = 8'd120,
    parameter int          MAX_LEN   = 1370
) (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  line_num,
    input logic        field2,
    input logic [10:0] hpos,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [7:0]  luma_code,
    input logic        cc_active,
    input logic        status_f1,
    input logic        status_f2
);
    logic [11:0] run_len;

    // Count the length of the current gate window.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_len <= '0;
        else if (cc_active) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> (luma_code == LEVEL_LO));

    assert_level_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cc_active |-> (luma_code >= LEVEL_LO && luma_code <= LEVEL_HI));

    assert_gate_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 12'(MAX_LEN));

    assert_gate_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> ($past(hpos, 2) == 11'(START_POS)) &&
            (($past(line_num, 2) == 10'(LINE_F1) && !$past(field2, 2)) ||
             ($past(line_num, 2) == 10'(LINE_F2) &&  $past(field2, 2))));

    assert_status_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($past(wr_addr[1]) ? status_f2 : status_f1));
endmodule

bind cc_line21_enc cc_line21_enc_chk #(
    .START_POS(START_POS), .LINE_F1(LINE_F1), .LINE_F2(LINE_F2),
    .LEVEL_LO(LEVEL_LO), .LEVEL_HI(LEVEL_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field2(field2),
    .hpos(hpos), .wr_en(wr_en), .wr_addr(wr_addr), .luma_code(luma_code),
    .cc_active(cc_active), .status_f1(status_f1), .status_f2(status_f2)
);

// File: tb/cc_line21_enc_test.sv
// Bench: sweeps whole lines, decodes the level stream at bit midpoints and
// compares against characters and parity computed here.
module cc_line21_enc_test;
    localparam int LO = 16, HI = 120, MID = 68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  line_num = '0;
    logic        field2 = 1'b0;
    logic [10:0] hpos = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [6:0]  wr_data = '0;
    logic        en_f1 = 1'b0, en_f2 = 1'b0;
    logic [7:0]  luma_code;
    logic        cc_active, status_f1, status_f2;

    int checks = 0, errors = 0;
    int act_cnt, first_h;
    int samp [0:1499];

    always #4 clk = ~clk;

    cc_line21_enc uut (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .field2(field2),
        .hpos(hpos), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_f1(en_f1), .en_f2(en_f2), .luma_code(luma_code),
        .cc_active(cc_active), .status_f1(status_f1), .status_f2(status_f2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit par_of(input logic [6:0] c);
        return ~(^c);
    endfunction

    task automatic host_write(input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Run one full line; optionally issue a write at hpos 800.
    task automatic run_line(input int ln, input bit f2, input bit mid_wr,
                            input logic [1:0] ma, input logic [6:0] md);
        act_cnt = 0; first_h = -1;
        line_num = 10'(ln); field2 = f2;
        for (int h = 0; h < 1716; h++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (cc_active) begin
                if (first_h < 0) first_h = h;
                if (act_cnt < 1500) samp[act_cnt] = int'(luma_code);
                act_cnt++;
            end
            hpos = 11'(h);
            if (mid_wr && h == 800) begin
                wr_en = 1'b1; wr_addr = ma; wr_data = md;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Decode a captured burst and compare with expected characters.
    task automatic check_burst(input logic [6:0] e1, input logic [6:0] e2, input string tag);
        logic [18:0] exp_bits;
        int ups;
        exp_bits = {par_of(e2), e2, par_of(e1), e1, 3'b100};
        check(act_cnt >= 1366 && act_cnt <= 1370, {"R3 length ", tag}, act_cnt, 1368);
        check(first_h == 286, {"R3 start ", tag}, first_h, 286);
        ups = 0;
        for (int i = 1; i < 340; i++)
            if (samp[i-1] <= MID && samp[i] > MID) ups++;
        check(ups == 7, {"R4 run-in ", tag}, ups, 7);
        for (int j = 0; j < 19; j++) begin
            int n, v;
            n = ((14 + 2 * j) * 1716) / 64;
            v = samp[n];
            check(v == LO || v == HI, {"R7 level ", tag}, v, exp_bits[j] ? HI : LO);
            check((v > MID) == exp_bits[j],
                  {j < 3 ? "R5 start bit " : "R6 data bit ", tag},
                  int'(v > MID), int'(exp_bits[j]));
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] a, b;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cc_active == 1'b0, "R1 gate", int'(cc_active), 0);
        check(luma_code == 8'(LO), "R1 level", int'(luma_code), LO);
        check(!status_f1 && !status_f2, "R1 status", int'({status_f2, status_f1}), 0);
        @(negedge clk); rst_n = 1'b1;

        // R8 status set, field one burst
        host_write(2'd0, 7'h41); host_write(2'd1, 7'h5A);
        check(status_f1 == 1'b1, "R8 set f1", int'(status_f1), 1);
        check(status_f2 == 1'b0, "R8 f2 untouched", int'(status_f2), 0);
        en_f1 = 1'b1;
        run_line(21, 1'b0, 1'b0, 2'd0, 7'd0);
        check_burst(7'h41, 7'h5A, "f1");
        check(status_f1 == 1'b0, "R8 clear f1", int'(status_f1), 0);

        // R9 missed slot sends nulls
        run_line(21, 1'b0, 1'b0, 2'd0, 7'd0);
        check_burst(7'h00, 7'h00, "null");

        // R2 wrong line, wrong field, disabled
        host_write(2'd0, 7'h33); host_write(2'd1, 7'h0F);
        run_line(20, 1'b0, 1'b0, 2'd0, 7'd0);
        check(act_cnt == 0, "R2 line 20", act_cnt, 0);
        run_line(21, 1'b1, 1'b0, 2'd0, 7'd0);
        check(act_cnt == 0, "R2 wrong field", act_cnt, 0);
        check(luma_code == 8'(LO), "R11 idle level", int'(luma_code), LO);
        en_f1 = 1'b0;
        run_line(21, 1'b0, 1'b0, 2'd0, 7'd0);
        check(act_cnt == 0, "R2 disabled", act_cnt, 0);
        check(status_f1 == 1'b1, "R2 status kept", int'(status_f1), 1);
        en_f1 = 1'b1;
        run_line(21, 1'b0, 1'b0, 2'd0, 7'd0);
        check_burst(7'h33, 7'h0F, "kept bytes");

        // Field two
        host_write(2'd2, 7'h7F); host_write(2'd3, 7'h01);
        check(status_f2 == 1'b1, "R8 set f2", int'(status_f2), 1);
        run_line(284, 1'b1, 1'b0, 2'd0, 7'd0);
        check(act_cnt == 0, "R2 f2 disabled", act_cnt, 0);
        en_f2 = 1'b1;
        run_line(284, 1'b0, 1'b0, 2'd0, 7'd0);
        check(act_cnt == 0, "R2 284 field one", act_cnt, 0);
        run_line(284, 1'b1, 1'b0, 2'd0, 7'd0);
        check_burst(7'h7F, 7'h01, "f2");
        check(status_f2 == 1'b0, "R8 clear f2", int'(status_f2), 0);

        // R10 write during burst is buffered
        host_write(2'd0, 7'h2A); host_write(2'd1, 7'h15);
        run_line(21, 1'b0, 1'b1, 2'd0, 7'h55);
        check_burst(7'h2A, 7'h15, "R10 current");
        check(status_f1 == 1'b1, "R10 status kept", int'(status_f1), 1);
        run_line(21, 1'b0, 1'b0, 2'd0, 7'd0);
        check_burst(7'h55, 7'h00, "R10 next");

        // Random characters on both fields
        for (int k = 0; k < 6; k++) begin
            bit f;
            a = 7'($urandom); b = 7'($urandom); f = 1'($urandom);
            host_write({f, 1'b0}, a); host_write({f, 1'b1}, b);
            run_line(f ? 284 : 21, f, 1'b0, 2'd0, 7'd0);
            check_burst(a, b, "random R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule